// File: doc/BRIEF.md
# Unlock-Protected Mode Control Register

This block is a byte-wide control register whose two mode bits drive chip-level behaviour and must not flip by accident. Software changes them only through a two-instruction sequence. The first instruction writes the new mode values together with an arming flag. The second instruction, which must come straight after, sets a commit flag. The new mode reaches the outputs two instruction boundaries later. This gap lets the processor redirect its program counter before the new mode takes hold.

A write to a mode bit that is not part of a valid sequence shows on the read port for a short time. It then falls back to the active value. The block uses an instruction-boundary pulse to mark the end of each instruction and a cycle strobe to mark the end of each instruction cycle. Every read or write of the register holds off interrupts for the first cycle of the next instruction. This keeps the sequence from being split. Each active mode bit is stored in three copies. A majority vote of the copies drives the output, and every instruction cycle rewrites all copies with the voted value.

Top module: `prot_mode_reg`

## Requirements
- R1: After reset, `mode_o` is 0, `rd_data_o` is 0x00 and `irq_block_o` is 0.
- R2: Register layout: bit 0 and bit 2 are the two mode bits (bit 0 maps to `mode_o[0]`, bit 2 to `mode_o[1]`), bit 7 is the arm flag and bit 6 is the commit flag. Bits 1, 3, 4 and 5 are plain storage. A read returns the value last written.
- R3: If a write with bit 7 = 1 and bit 6 = 0 (arm) is followed in the very next instruction by a write with bit 6 = 1 whose mode bits equal the armed ones (commit), `mode_o` takes the armed values in the cycle after the second instruction boundary that follows the commit instruction's boundary. After that, bits 7 and 6 read 0.
- R4: The arming step may span several consecutive instructions. A plain write just before the arm write is accepted, and if more than one arm write comes in a row, the last one gives the pending values.
- R5: If a mode bit is written without a valid sequence, `mode_o` does not change. The read port shows the written value and returns to the active value at the second instruction boundary after the boundary of the changing instruction.
- R6: An armed sequence aborts if the next instruction is anything other than a matching commit: no write, a write without bit 6, or a commit whose mode bits differ from the armed ones. At that boundary the mode bits read back the active value and bit 7 reads 0, and `mode_o` never changes.
- R7: A commit write with no arming before it has no effect on `mode_o`, and bit 6 reads 0 after that instruction's boundary.
- R8: An instruction that reads or writes the register drives `irq_block_o` high from its boundary until the end of the first instruction cycle of the next instruction. An instruction with no access leaves it low.
- R9: Each mode bit is kept in three copies and a two-of-three vote drives `mode_o`. A disturbance of one copy (`upset_i` bit 3*i+k flips copy k of mode bit i) does not change `mode_o` and is repaired at the next `cyc_i` strobe.
- R10: While a committed change waits to apply, writes to bits 7, 6, 2 and 0 are ignored.
- R11: All delays count instruction boundaries, so the apply point does not depend on how many cycles each instruction takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_i | input | 1 | Strobe at the last clock of each instruction cycle |
| instr_end_i | input | 1 | Strobe at the last clock of each instruction (coincides with `cyc_i`) |
| wr_en_i | input | 1 | Register write (read-modify-write result) |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Register read access |
| upset_i | input | 6 | Flips individual shadow copies (disturbance model) |
| rd_data_o | output | 8 | Register read value |
| mode_o | output | 2 | Active, voted mode bits |
| irq_block_o | output | 1 | Interrupt generation hold-off |

## Verification
Two events can land in the same clock edge: applying a committed mode, and the voted repair of the shadow copies. Both happen at an instruction boundary, because every boundary is also a cycle strobe. The bench makes them meet by disturbing a shadow copy and then committing and applying a new mode. It also sweeps every pair of mode values through the apply path. Each result is judged by the exact boundary at which `mode_o` and the read value change. The interrupt hold-off is checked against the same boundaries.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned N_PROT     = 2;
  localparam int unsigned N_COPY     = 3;
  localparam int unsigned ARM_POS    = 7;
  localparam int unsigned COMMIT_POS = 6;
  localparam int unsigned DLY_W      = 2;
  localparam logic [DLY_W-1:0] SETTLE_DLY = 2'd2;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ARMED, SEQ_APPLY} seq_state_e;

  // mode bit i lives at register bit 2*i
  function automatic int unsigned prot_pos(int unsigned i);
    return 2 * i;
  endfunction

  function automatic logic [REG_W-1:0] plain_mask();
    logic [REG_W-1:0] m;
    m = '1;
    m[ARM_POS] = 1'b0;
    m[COMMIT_POS] = 1'b0;
    for (int unsigned i = 0; i < N_PROT; i++) m[prot_pos(i)] = 1'b0;
    return m;
  endfunction

  function automatic logic [N_PROT-1:0] get_prot(logic [REG_W-1:0] d);
    logic [N_PROT-1:0] p;
    for (int unsigned i = 0; i < N_PROT; i++) p[i] = d[prot_pos(i)];
    return p;
  endfunction
endpackage

// File: rtl/tmr_cell.sv
module tmr_cell
  import pmr_pkg::*;
#(
  parameter int unsigned COPIES = N_COPY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scrub_i,
  input  logic              load_i,
  input  logic              load_val_i,
  input  logic [COPIES-1:0] upset_i,
  output logic              val_o
);
  localparam int unsigned HALF = COPIES / 2;

  logic [COPIES-1:0] copy_q;
  logic              vote;

  always_comb begin
    int unsigned ones;
    ones = 0;
    for (int unsigned k = 0; k < COPIES; k++) ones += int'(copy_q[k]);
    vote = (ones > HALF);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     copy_q <= '0;
    else if (load_i) copy_q <= {COPIES{load_val_i}};
    else             copy_q <= (scrub_i ? {COPIES{vote}} : copy_q) ^ upset_i;
  end

  assign val_o = vote;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import pmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_end_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [N_PROT-1:0] active_i,
  output logic [N_PROT-1:0] vis_prot_o,
  output logic              arm_o,
  output logic              commit_o,
  output logic              apply_o,
  output logic [N_PROT-1:0] pend_o
);
  seq_state_e        state_q;
  logic [DLY_W-1:0]  dly_q, rv_q;
  logic [N_PROT-1:0] pend_q, vis_q;
  logic              arm_q, commit_q;
  logic              wr_seen_q;
  logic [REG_W-1:0]  wr_last_q;

  logic              hold, cur_wr, arm_w, com_w, com_ok;
  logic [REG_W-1:0]  cur_d;
  logic [N_PROT-1:0] eff_prot;

  // the write that lands on the boundary clock belongs to the ending instruction
  assign hold     = (state_q == SEQ_APPLY);
  assign cur_wr   = wr_en_i | wr_seen_q;
  assign cur_d    = wr_en_i ? wr_data_i : wr_last_q;
  assign eff_prot = (wr_en_i && !hold) ? get_prot(wr_data_i) : vis_q;
  assign arm_w    = cur_wr & cur_d[ARM_POS] & ~cur_d[COMMIT_POS];
  assign com_w    = cur_wr & cur_d[COMMIT_POS];
  assign com_ok   = com_w && (get_prot(cur_d) == pend_q);
  assign apply_o  = instr_end_i && hold && (dly_q == 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      dly_q     <= '0;
      rv_q      <= '0;
      pend_q    <= '0;
      vis_q     <= '0;
      arm_q     <= 1'b0;
      commit_q  <= 1'b0;
      wr_seen_q <= 1'b0;
      wr_last_q <= '0;
    end else begin
      if (wr_en_i) begin
        wr_seen_q <= 1'b1;
        wr_last_q <= wr_data_i;
        if (!hold) begin
          vis_q    <= get_prot(wr_data_i);
          arm_q    <= wr_data_i[ARM_POS];
          commit_q <= wr_data_i[COMMIT_POS];
        end
      end
      if (instr_end_i) begin
        wr_seen_q <= 1'b0;
        unique case (state_q)
          SEQ_IDLE: begin
            if (arm_w) begin
              state_q <= SEQ_ARMED;
              pend_q  <= get_prot(cur_d);
              rv_q    <= '0;
            end else begin
              arm_q    <= 1'b0;
              commit_q <= 1'b0;
              if (rv_q == 1) begin
                vis_q <= active_i;
                rv_q  <= '0;
              end else if (rv_q != 0) begin
                rv_q <= rv_q - 1'b1;
              end else if (eff_prot != active_i) begin
                rv_q <= SETTLE_DLY;
              end
            end
          end
          SEQ_ARMED: begin
            if (com_ok) begin
              state_q <= SEQ_APPLY;
              dly_q   <= SETTLE_DLY;
            end else if (arm_w) begin
              pend_q <= get_prot(cur_d);
            end else begin
              state_q  <= SEQ_IDLE;
              vis_q    <= active_i;
              arm_q    <= 1'b0;
              commit_q <= 1'b0;
            end
          end
          SEQ_APPLY: begin
            if (dly_q == 1) begin
              state_q  <= SEQ_IDLE;
              vis_q    <= pend_q;
              arm_q    <= 1'b0;
              commit_q <= 1'b0;
              dly_q    <= '0;
            end else begin
              dly_q <= dly_q - 1'b1;
            end
          end
          default: state_q <= SEQ_IDLE;
        endcase
      end
    end
  end

  assign vis_prot_o = vis_q;
  assign arm_o      = arm_q;
  assign commit_o   = commit_q;
  assign pend_o     = pend_q;
endmodule

// File: rtl/irq_guard.sv
module irq_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_i,
  input  logic instr_end_i,
  input  logic acc_i,
  output logic blk_o
);
  logic seen_q, blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      blk_q  <= 1'b0;
    end else if (instr_end_i) begin
      blk_q  <= seen_q | acc_i;
      seen_q <= 1'b0;
    end else begin
      if (acc_i) seen_q <= 1'b1;
      if (cyc_i) blk_q  <= 1'b0;
    end
  end

  assign blk_o = blk_q;
endmodule

// File: rtl/prot_mode_reg.sv
module prot_mode_reg
  import pmr_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cyc_i,
  input  logic                     instr_end_i,
  input  logic                     wr_en_i,
  input  logic [REG_W-1:0]         wr_data_i,
  input  logic                     rd_en_i,
  input  logic [N_PROT*N_COPY-1:0] upset_i,
  output logic [REG_W-1:0]         rd_data_o,
  output logic [N_PROT-1:0]        mode_o,
  output logic                     irq_block_o
);
  localparam logic [REG_W-1:0] PLAIN_M = plain_mask();

  logic [N_PROT-1:0] vis_prot, pend, active;
  logic              arm, commit, apply;
  logic [REG_W-1:0]  plain_q;

  seq_ctrl u_seq (
    .clk_i, .rst_ni, .instr_end_i, .wr_en_i, .wr_data_i,
    .active_i   (active),
    .vis_prot_o (vis_prot),
    .arm_o      (arm),
    .commit_o   (commit),
    .apply_o    (apply),
    .pend_o     (pend)
  );

  for (genvar i = 0; i < N_PROT; i++) begin : g_shadow
    tmr_cell #(.COPIES(N_COPY)) u_cell (
      .clk_i, .rst_ni,
      .scrub_i    (cyc_i),
      .load_i     (apply),
      .load_val_i (pend[i]),
      .upset_i    (upset_i[i*N_COPY +: N_COPY]),
      .val_o      (active[i])
    );
  end

  irq_guard u_guard (
    .clk_i, .rst_ni, .cyc_i, .instr_end_i,
    .acc_i (wr_en_i | rd_en_i),
    .blk_o (irq_block_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      plain_q <= '0;
    else if (wr_en_i) plain_q <= wr_data_i & PLAIN_M;
  end

  always_comb begin
    rd_data_o = plain_q;
    rd_data_o[ARM_POS]    = arm;
    rd_data_o[COMMIT_POS] = commit;
    for (int unsigned i = 0; i < N_PROT; i++) rd_data_o[prot_pos(i)] = vis_prot[i];
  end

  assign mode_o = active;
endmodule

// File: rtl/prot_mode_reg_chk.sv
module prot_mode_reg_chk
  import pmr_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cyc_i,
  input logic                     instr_end_i,
  input logic                     wr_en_i,
  input logic [REG_W-1:0]         wr_data_i,
  input logic                     rd_en_i,
  input logic [N_PROT*N_COPY-1:0] upset_i,
  input logic [REG_W-1:0]         rd_data_o,
  input logic [N_PROT-1:0]        mode_o,
  input logic                     irq_block_o
);
  // R3
  mode_needs_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o) && $past(upset_i) == '0) |-> $past(rd_data_o[COMMIT_POS]));

  // R11
  mode_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o) && $past(upset_i) == '0) |-> $past(instr_end_i));

  // R8
  blk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_block_o) |-> $past(instr_end_i));

  // R8
  blk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_block_o) |-> $past(cyc_i));

  // R7
  commit_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[COMMIT_POS]) |-> $past(wr_en_i));
endmodule

bind prot_mode_reg prot_mode_reg_chk u_chk (.*);

// File: tb/prot_mode_reg_tb_top.sv
module prot_mode_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cyc_i = 1'b0, instr_end_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [5:0] upset_i = '0;
  logic [7:0] rd_data_o;
  logic [1:0] mode_o;
  logic       irq_block_o;

  int n_chk = 0, n_err = 0;
  int cur = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prot_mode_reg dut_i (.*);

  function automatic logic [7:0] pb(int v);
    return {5'b0, v[1], 1'b0, v[0]};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one instruction of ncyc cycles, two clocks per cycle; access on the first clock
  task automatic instr(input logic w, input logic [7:0] d, input logic r, input int ncyc);
    for (int c = 0; c < ncyc; c++) begin
      wr_en_i = (c == 0) && w; rd_en_i = (c == 0) && r; wr_data_i = d;
      @(negedge clk_i);
      wr_en_i = 1'b0; rd_en_i = 1'b0;
      cyc_i = 1'b1; instr_end_i = (c == ncyc - 1);
      @(negedge clk_i);
      cyc_i = 1'b0; instr_end_i = 1'b0;
    end
  endtask

  task automatic nop();
    instr(1'b0, 8'h00, 1'b0, 1);
  endtask

  task automatic apply_seq(int t);
    int old = cur;
    instr(1'b1, 8'h80 | pb(t), 1'b0, 1);
    chk("R2", "armed readback", rd_data_o, 8'h80 | pb(t));
    instr(1'b1, 8'hC0 | pb(t), 1'b0, 1);
    chk("R3", "mode at commit", mode_o, old);
    nop();
    chk("R3", "mode one later", mode_o, old);
    nop();
    chk("R3", "mode applied", mode_o, t);
    chk("R3", "flags cleared", rd_data_o, pb(t));
    cur = t;
  endtask

  task automatic upset(logic [5:0] m);
    upset_i = m;
    @(negedge clk_i);
    upset_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1", "mode", mode_o, 0);
    chk("R1", "read", rd_data_o, 0);
    chk("R1", "irq", irq_block_o, 0);

    // R2 plain storage
    instr(1'b1, 8'h3A, 1'b0, 1);
    chk("R2", "plain bits", rd_data_o, 8'h3A);
    instr(1'b1, 8'h00, 1'b0, 1);
    chk("R2", "plain cleared", rd_data_o, 8'h00);

    // R3 sweep over all mode pairs
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        apply_seq(a);
        apply_seq(b);
      end

    // R11 long instructions do not change the apply point
    instr(1'b1, 8'h80 | pb(cur ^ 3), 1'b0, 3);
    instr(1'b1, 8'hC0 | pb(cur ^ 3), 1'b0, 2);
    instr(1'b0, 8'h00, 1'b0, 4);
    chk("R11", "mode after long instr", mode_o, cur);
    instr(1'b0, 8'h00, 1'b0, 3);
    chk("R11", "mode applied", mode_o, cur ^ 3);
    cur = cur ^ 3;

    // R4 two-instruction arm and repeated arm
    apply_seq(0);
    instr(1'b1, pb(3), 1'b0, 1);
    instr(1'b1, 8'h80 | pb(3), 1'b0, 1);
    instr(1'b1, 8'hC0 | pb(3), 1'b0, 1);
    nop(); nop();
    chk("R4", "mask then arm", mode_o, 3);
    cur = 3;
    instr(1'b1, 8'h80 | pb(1), 1'b0, 1);
    instr(1'b1, 8'h80 | pb(2), 1'b0, 1);
    instr(1'b1, 8'hC0 | pb(2), 1'b0, 1);
    nop(); nop();
    chk("R4", "last arm wins", mode_o, 2);
    cur = 2;

    // R5 unauthorised change reverts
    for (int t = 0; t < 4; t++) begin
      if (t == cur) continue;
      instr(1'b1, pb(t), 1'b0, 1);
      chk("R5", "shows written", rd_data_o, pb(t));
      nop();
      chk("R5", "still written", rd_data_o, pb(t));
      nop();
      chk("R5", "reverted", rd_data_o, pb(cur));
      chk("R5", "mode kept", mode_o, cur);
    end

    // R6 aborts
    instr(1'b1, 8'h80 | pb(cur ^ 1), 1'b0, 1);
    nop();
    chk("R6", "abort by idle", rd_data_o, pb(cur));
    nop(); nop();
    chk("R6", "mode kept idle", mode_o, cur);
    instr(1'b1, 8'h80 | pb(cur ^ 2), 1'b0, 1);
    instr(1'b1, 8'h20, 1'b0, 1);
    chk("R6", "abort by plain write", rd_data_o, 8'h20 | pb(cur));
    instr(1'b1, pb(cur), 1'b0, 1);
    instr(1'b1, 8'h80 | pb(cur ^ 3), 1'b0, 1);
    instr(1'b1, 8'hC0 | pb(cur ^ 1), 1'b0, 1);
    chk("R6", "abort by mismatch", rd_data_o, pb(cur));
    nop(); nop(); nop();
    chk("R6", "mode kept mismatch", mode_o, cur);

    // R7 commit alone
    instr(1'b1, 8'h40 | pb(cur), 1'b0, 1);
    chk("R7", "commit cleared", rd_data_o, pb(cur));
    nop(); nop();
    chk("R7", "mode kept", mode_o, cur);

    // R10 writes ignored while waiting to apply
    instr(1'b1, 8'h80 | pb(cur ^ 3), 1'b0, 1);
    instr(1'b1, 8'hC0 | pb(cur ^ 3), 1'b0, 1);
    instr(1'b1, 8'h00, 1'b0, 1);
    chk("R10", "write ignored", rd_data_o, 8'hC0 | pb(cur ^ 3));
    nop();
    chk("R10", "applied", mode_o, cur ^ 3);
    cur = cur ^ 3;

    // R8 interrupt hold-off
    instr(1'b1, pb(cur), 1'b0, 1);
    chk("R8", "after write", irq_block_o, 1);
    @(negedge clk_i);
    chk("R8", "held until next cycle", irq_block_o, 1);
    nop();
    chk("R8", "released", irq_block_o, 0);
    instr(1'b0, 8'h00, 1'b1, 2);
    chk("R8", "after read", irq_block_o, 1);
    instr(1'b0, 8'h00, 1'b0, 2);
    chk("R8", "no access", irq_block_o, 0);

    // R9 single-copy disturbances are outvoted and scrubbed
    for (int i = 0; i < 2; i++) begin
      for (int k = 0; k < 3; k++) begin
        upset(6'(1) << (3*i + k));
        chk("R9", "vote holds", mode_o, cur);
        nop();
      end
      chk("R9", "after scrubs", mode_o, cur);
    end
    // disturbance meeting an apply
    upset(6'b001001);
    instr(1'b1, 8'h80 | pb(cur ^ 3), 1'b0, 1);
    instr(1'b1, 8'hC0 | pb(cur ^ 3), 1'b0, 1);
    upset(6'b010010);
    chk("R9", "vote before apply", mode_o, cur);
    nop(); nop();
    chk("R9", "apply over disturbance", mode_o, cur ^ 3);
    cur = cur ^ 3;
    upset(6'b100100);
    nop();
    upset(6'b010010);
    chk("R9", "repaired after apply", mode_o, cur);

    finish_run();
  end
endmodule